// File: doc/BRIEF.md
# Bitmap-Mode Video Memory Fetch Address Generator

This block drives the video-memory read addresses that a tile-based display processor needs while it paints a bitmap-mode screen of 32 columns by 24 character rows. A frame starts with a one-cycle start pulse. For every scan line the block walks all 32 cells. For each cell it issues three reads in a fixed order: the name-table byte, then the colour byte, then the pattern byte. The address of each read is held until memory answers with a data-valid strobe. The name byte that comes back is latched and used to form the other two addresses.

The colour and pattern offsets are built from the screen third, the character code and the line within the character. Each offset is passed through a programmable AND mask and then placed in one of two 8 KiB halves of memory. The pattern mask borrows its low eleven bits from the colour mask. Because of this, layouts where the thirds share tables, where tables repeat, or where tables have holes all come out of the mask settings.

The three layout registers are captured only on the start pulse. A layout change therefore never lands in the middle of a frame.

Top module: `vram_fetch_gen`

## Requirements
- R1: After reset, and until the first start pulse, `fetchReq` is 0 and `fetchKind` is 0 (idle).
- R2: In the cycle after a start pulse, the block requests the name byte of row 0, column 0. Its address is `nameBase` times 0x400.
- R3: Each cell is fetched in the order name, colour, pattern. `fetchKind` reads 1 for name, 2 for colour and 3 for pattern. A fetch ends on a cycle where `dataValid` is 1.
- R4: While `dataValid` is 0 and no start pulse arrives, `fetchAddr` and `fetchKind` stay unchanged.
- R5: The name address is `nameBase`*0x400 + row*32 + column. The column advances after each pattern fetch. The line advances after column 31. The row advances after line 7.
- R6: The colour mask is `colorCfg[6:0]` shifted left by six, with ones in bits 5:0. The colour address is (offset AND colour mask) plus 0x2000 if `colorCfg[7]` is 1, or plus 0 if it is 0.
- R7: The pattern mask is `patternCfg[1:0]` in bits 12:11 and colour-mask bits 10:0 below them. The pattern address is (offset AND pattern mask) plus 0x2000 if `patternCfg[2]` is 1, or plus 0 if it is 0.
- R8: The unmasked offset is third*0x800 + name byte*8 + line. Here third = row/8, and the name byte is the value returned by the name fetch of the same cell.
- R9: `nameBase`, `colorCfg` and `patternCfg` are sampled only on the start pulse. Changes to them during a frame do not affect any address of that frame.
- R10: After the pattern fetch of row 23, line 7, column 31, `fetchReq` drops to 0 and stays there, even if `dataValid` is asserted, until the next start pulse.
- R11: A start pulse arriving mid-frame restarts the frame at row 0, line 0, column 0 with the newly sampled registers. This holds even when the pulse coincides with `dataValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | One-cycle start-of-frame pulse |
| nameBase | input | 4 | Name-table base in 0x400 units |
| colorCfg | input | 8 | Bit 7 colour base select, bits 6:0 colour mask |
| patternCfg | input | 3 | Bit 2 pattern base select, bits 1:0 top pattern-mask bits |
| dataValid | input | 1 | Memory has returned data for the current address |
| dataIn | input | 8 | Returned byte (only the name byte is used) |
| fetchReq | output | 1 | An address is being presented |
| fetchKind | output | 2 | 0 idle, 1 name, 2 colour, 3 pattern |
| fetchAddr | output | 14 | Video-memory read address |

## Verification
The start pulse and a data-valid handshake can land in the same cycle. When they do, the restart must win, and the cell advance or name latch that the handshake would have caused must be dropped. The bench provokes this by raising `frameStart` together with `dataValid` during a name fetch several cells into a frame, with new register values on the inputs. It then judges the following address, which must be row 0, column 0 under the new name base, and the following colour and pattern addresses under the new masks.

// File: rtl/vram_fetch_pkg.sv
package vram_fetch_pkg;

  typedef enum logic [1:0] {
    KIND_IDLE    = 2'd0,
    KIND_NAME    = 2'd1,
    KIND_COLOR   = 2'd2,
    KIND_PATTERN = 2'd3
  } fetchKindE;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;    // frame restart: sample layout, clear position
    logic latchName;  // capture returned name byte
    logic stepCell;   // cell complete, advance position
  } dpStrobeS;

endpackage

// File: rtl/vram_fetch_ctrl.sv
module vram_fetch_ctrl
  import vram_fetch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frameStart,
  input  logic      dataValid,
  input  logic      lastCell,
  output fetchKindE kind,
  output dpStrobeS  strobe
);

  always_comb begin
    strobe.loadCfg   = frameStart;
    strobe.latchName = (kind == KIND_NAME) && dataValid && !frameStart;
    strobe.stepCell  = (kind == KIND_PATTERN) && dataValid && !frameStart;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      kind <= KIND_IDLE;
    end else if (frameStart) begin
      kind <= KIND_NAME;
    end else if (dataValid) begin
      unique case (kind)
        KIND_NAME:    kind <= KIND_COLOR;
        KIND_COLOR:   kind <= KIND_PATTERN;
        KIND_PATTERN: kind <= lastCell ? KIND_IDLE : KIND_NAME;
        default:      kind <= KIND_IDLE;
      endcase
    end
  end

  AST_NAME_THEN_COLOR: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_NAME && dataValid && !frameStart) |=> kind == KIND_COLOR); // R3
  AST_COLOR_THEN_PATTERN: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_COLOR && dataValid && !frameStart) |=> kind == KIND_PATTERN); // R3
  AST_END_GOES_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stepCell && lastCell) |=> kind == KIND_IDLE); // R10
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (kind == KIND_IDLE && !frameStart) |=> kind == KIND_IDLE); // R10
  AST_RESTART_NAME: assert property (@(posedge clk) disable iff (!rstN)
    frameStart |=> kind == KIND_NAME); // R11

endmodule

// File: rtl/vram_fetch_dp.sv
module vram_fetch_dp
  import vram_fetch_pkg::*;
#(
  parameter int COLS           = 32,
  parameter int ROWS           = 24,
  parameter int LINES          = 8,
  parameter int ROWS_PER_THIRD = 8,
  parameter int ADDR_W         = 14,
  parameter int NBASE_W        = 4,
  parameter int CODE_W         = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeS          strobe,
  input  fetchKindE         kind,
  input  logic [NBASE_W-1:0] nameBase,
  input  logic [7:0]        colorCfg,
  input  logic [2:0]        patternCfg,
  input  logic [CODE_W-1:0] dataIn,
  output logic              lastCell,
  output logic [ADDR_W-1:0] fetchAddr
);

  localparam int COL_W   = $clog2(COLS);
  localparam int ROW_W   = $clog2(ROWS);
  localparam int LINE_W  = $clog2(LINES);
  localparam int THIRD_W = $clog2((ROWS + ROWS_PER_THIRD - 1) / ROWS_PER_THIRD);
  localparam int OFF_W   = ADDR_W - 1;
  localparam int IDX_W   = ADDR_W - NBASE_W;
  localparam int LOW_W   = CODE_W + LINE_W;  // bits shared by both masks
  localparam int FILL_W  = OFF_W - 7;        // ones below the 7 mask bits

  logic [NBASE_W-1:0] nameBaseQ;
  logic [7:0]         colorCfgQ;
  logic [2:0]         patternCfgQ;
  logic [CODE_W-1:0]  nameQ;
  logic [ROW_W-1:0]   row;
  logic [COL_W-1:0]   col;
  logic [LINE_W-1:0]  line;

  logic [THIRD_W-1:0] third;
  logic [OFF_W-1:0]   rawOff;
  logic [OFF_W-1:0]   colorMask;
  logic [OFF_W-1:0]   patMask;
  logic [IDX_W-1:0]   nameIdx;
  logic [ADDR_W-1:0]  nameAddr;
  logic [ADDR_W-1:0]  colorAddr;
  logic [ADDR_W-1:0]  patAddr;

  assign lastCell = (col == COL_W'(COLS - 1)) && (line == LINE_W'(LINES - 1))
                 && (row == ROW_W'(ROWS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      nameBaseQ   <= '0;
      colorCfgQ   <= '0;
      patternCfgQ <= '0;
      nameQ       <= '0;
      row         <= '0;
      col         <= '0;
      line        <= '0;
    end else if (strobe.loadCfg) begin
      nameBaseQ   <= nameBase;
      colorCfgQ   <= colorCfg;
      patternCfgQ <= patternCfg;
      row         <= '0;
      col         <= '0;
      line        <= '0;
    end else begin
      if (strobe.latchName) nameQ <= dataIn;
      if (strobe.stepCell) begin
        if (col == COL_W'(COLS - 1)) begin
          col <= '0;
          if (line == LINE_W'(LINES - 1)) begin
            line <= '0;
            if (row != ROW_W'(ROWS - 1)) row <= row + 1'b1;
          end else begin
            line <= line + 1'b1;
          end
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

  always_comb begin
    third     = THIRD_W'(row / ROW_W'(ROWS_PER_THIRD));
    rawOff    = {third, nameQ, line};
    colorMask = {colorCfgQ[6:0], {FILL_W{1'b1}}};
    patMask   = {patternCfgQ[1:0], colorMask[LOW_W-1:0]};
    nameIdx   = IDX_W'(row) * IDX_W'(COLS) + IDX_W'(col);
    nameAddr  = {nameBaseQ, nameIdx};
    colorAddr = {colorCfgQ[7], rawOff & colorMask};
    patAddr   = {patternCfgQ[2], rawOff & patMask};
    unique case (kind)
      KIND_NAME:    fetchAddr = nameAddr;
      KIND_COLOR:   fetchAddr = colorAddr;
      KIND_PATTERN: fetchAddr = patAddr;
      default:      fetchAddr = '0;
    endcase
  end

  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    row < ROW_W'(ROWS)); // R5
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.loadCfg |=> ($stable(colorCfgQ) && $stable(patternCfgQ) && $stable(nameBaseQ))); // R9
  AST_NAME_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchName |=> $stable(nameQ)); // R8
  AST_RESTART_ORIGIN: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCfg |=> (row == '0 && col == '0 && line == '0)); // R11

endmodule

// File: rtl/vram_fetch_gen.sv
module vram_fetch_gen
  import vram_fetch_pkg::*;
#(
  parameter int COLS           = 32,
  parameter int ROWS           = 24,
  parameter int LINES          = 8,
  parameter int ROWS_PER_THIRD = 8,
  parameter int ADDR_W         = 14,
  parameter int NBASE_W        = 4,
  parameter int CODE_W         = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameStart,
  input  logic [NBASE_W-1:0] nameBase,
  input  logic [7:0]         colorCfg,
  input  logic [2:0]         patternCfg,
  input  logic               dataValid,
  input  logic [CODE_W-1:0]  dataIn,
  output logic               fetchReq,
  output logic [1:0]         fetchKind,
  output logic [ADDR_W-1:0]  fetchAddr
);

  fetchKindE kind;
  dpStrobeS  strobe;
  logic      lastCell;

  vram_fetch_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .frameStart(frameStart),
    .dataValid (dataValid),
    .lastCell  (lastCell),
    .kind      (kind),
    .strobe    (strobe)
  );

  vram_fetch_dp #(
    .COLS(COLS), .ROWS(ROWS), .LINES(LINES), .ROWS_PER_THIRD(ROWS_PER_THIRD),
    .ADDR_W(ADDR_W), .NBASE_W(NBASE_W), .CODE_W(CODE_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .kind      (kind),
    .nameBase  (nameBase),
    .colorCfg  (colorCfg),
    .patternCfg(patternCfg),
    .dataIn    (dataIn),
    .lastCell  (lastCell),
    .fetchAddr (fetchAddr)
  );

  assign fetchReq  = (kind != KIND_IDLE);
  assign fetchKind = kind;

  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (fetchReq && !dataValid && !frameStart) |=> ($stable(fetchAddr) && $stable(fetchKind))); // R4
  AST_NAME_IN_TABLE: assert property (@(posedge clk) disable iff (!rstN)
    (fetchKind == 2'd1) |-> (fetchAddr[ADDR_W-NBASE_W-1:0] < (ADDR_W-NBASE_W)'(ROWS*COLS))); // R5
  AST_NO_REQ_IN_RESET: assert property (@(posedge clk)
    !rstN |=> !fetchReq); // R1

endmodule

// File: tb/sim_vram_fetch_gen.sv
module sim_vram_fetch_gen;

  logic       clk = 1'b0;
  logic       rstN;
  logic       frameStart;
  logic [3:0] nameBase;
  logic [7:0] colorCfg;
  logic [2:0] patternCfg;
  logic       dataValid;
  logic [7:0] dataIn;
  logic       fetchReq;
  logic [1:0] fetchKind;
  logic [13:0] fetchAddr;

  int nChecks = 0;
  int nFails  = 0;

  always #10 clk = ~clk;  // 50 MHz

  vram_fetch_gen u0 (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .nameBase(nameBase),
    .colorCfg(colorCfg), .patternCfg(patternCfg), .dataValid(dataValid),
    .dataIn(dataIn), .fetchReq(fetchReq), .fetchKind(fetchKind), .fetchAddr(fetchAddr)
  );

  // {nameBase, colorCfg, patternCfg, name byte}
  localparam logic [31:0] VECS [8] = '{
    32'h06_FF_07_A5, 32'h0E_9F_03_3C, 32'h00_00_00_FF, 32'h03_7F_04_81,
    32'h0F_80_05_00, 32'h01_1F_02_5A, 32'h0A_3F_06_C3, 32'h05_82_01_F0
  };

  function automatic int cMask(int c);
    return ((c & 127) << 6) | 63;
  endfunction
  function automatic int mdlOff(int row, int code, int line);
    return (row / 8) * 2048 + code * 8 + line;
  endfunction
  function automatic int mdlName(int n, int row, int col);
    return n * 1024 + row * 32 + col;
  endfunction
  function automatic int mdlColor(int c, int off);
    return ((c >> 7) & 1) * 8192 + (off & cMask(c));
  endfunction
  function automatic int mdlPat(int c, int p, int off);
    return ((p >> 2) & 1) * 8192 + (off & (((p & 3) << 11) | (cMask(c) & 2047)));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
  endtask

  task automatic expectFetch(input int kind, input int addr, input int data, input string tag);
    chk(fetchReq == 1'b1 && fetchKind == kind, {tag, " kind R3"}, fetchKind, kind);
    chk(fetchAddr == addr, tag, fetchAddr, addr);
    dataValid = 1'b1;
    dataIn    = data[7:0];
    @(negedge clk);
    dataValid = 1'b0;
  endtask

  task automatic doCell(input int n, input int c, input int p, input int row,
                        input int line, input int col, input int code, input string tag);
    int off;
    off = mdlOff(row, code, line);
    expectFetch(1, mdlName(n, row, col), code, {tag, " name R5"});
    expectFetch(2, mdlColor(c, off), 8'h11, {tag, " colour R6 R8"});
    expectFetch(3, mdlPat(c, p, off), 8'h22, {tag, " pattern R7 R8"});
  endtask

  task automatic pulseFrame();
    frameStart = 1'b1;
    @(negedge clk);
    frameStart = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL R10 watchdog expired act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    rstN = 1'b0; frameStart = 1'b0; nameBase = '0; colorCfg = '0;
    patternCfg = '0; dataValid = 1'b0; dataIn = '0;
    repeat (3) @(negedge clk);
    chk(fetchReq == 1'b0 && fetchKind == 2'd0, "R1 in reset", fetchKind, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(fetchReq == 1'b0 && fetchKind == 2'd0, "R1 before first frame", fetchKind, 0);

    // vector table: first two cells of a frame per layout
    for (int i = 0; i < 8; i++) begin
      int n, c, p, code;
      n = VECS[i][27:24]; c = VECS[i][23:16]; p = VECS[i][10:8]; code = VECS[i][7:0];
      nameBase = n[3:0]; colorCfg = c[7:0]; patternCfg = p[2:0];
      pulseFrame();
      // R9: inputs move right after sampling
      nameBase = ~nameBase; colorCfg = ~colorCfg; patternCfg = ~patternCfg;
      chk(fetchAddr == n * 1024, "R2 first name address", fetchAddr, n * 1024);
      for (int w = 0; w < 2; w++) begin
        @(negedge clk);
        chk(fetchAddr == n * 1024 && fetchKind == 2'd1, "R4 hold while not valid",
            fetchAddr, n * 1024);
      end
      doCell(n, c, p, 0, 0, 0, code, "R9 vec cell0");
      doCell(n, c, p, 0, 0, 1, code ^ 8'hFF, "R9 vec cell1");
    end

    // full frame, hybrid layout: shared colour table, three pattern tables
    nameBase = 4'h6; colorCfg = 8'h9F; patternCfg = 3'h3;
    pulseFrame();
    nameBase = 4'h1; colorCfg = 8'h00; patternCfg = 3'h4;  // ignored (R9)
    for (int row = 0; row < 24; row++)
      for (int line = 0; line < 8; line++)
        for (int col = 0; col < 32; col++)
          doCell(6, 8'h9F, 3, row, line, col, ((row * 32 + col) ^ (line * 29)) & 255,
                 "R5 frame");
    for (int k = 0; k < 3; k++) begin
      dataValid = 1'b1;
      chk(fetchReq == 1'b0 && fetchKind == 2'd0, "R10 idle after frame", fetchKind, 0);
      @(negedge clk);
    end
    dataValid = 1'b0;
    chk(fetchReq == 1'b0, "R10 still idle", fetchReq, 0);

    // restart coinciding with a handshake
    nameBase = 4'h2; colorCfg = 8'hFF; patternCfg = 3'h7;
    pulseFrame();
    for (int col = 0; col < 3; col++)
      doCell(2, 8'hFF, 7, 0, 0, col, col + 8'h40, "R11 pre");
    chk(fetchKind == 2'd1 && fetchAddr == mdlName(2, 0, 3), "R11 at col3",
        fetchAddr, mdlName(2, 0, 3));
    nameBase = 4'h9; colorCfg = 8'h00; patternCfg = 3'h0;
    frameStart = 1'b1; dataValid = 1'b1; dataIn = 8'hEE;
    @(negedge clk);
    frameStart = 1'b0; dataValid = 1'b0;
    chk(fetchKind == 2'd1 && fetchAddr == 9 * 1024, "R11 restart origin",
        fetchAddr, 9 * 1024);
    doCell(9, 0, 0, 0, 0, 0, 8'h7B, "R11 after restart");
    doCell(9, 0, 0, 0, 0, 1, 8'h03, "R11 second cell");

    summary();
    $finish;
  end

endmodule